// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block sits beside the fetch and decode stages of a small processor. It holds the control registers that govern exceptions: a two-bit status word (global interrupt enable and user-mode flag), a shadow copy of that word saved on entry, a per-line interrupt enable mask, a read-only pending view and a read-only processor identifier. Each cycle it decides whether an exception is taken. The possible causes are an enabled hardware interrupt, an unimplemented-instruction strobe and a software-trap strobe.

When it takes an exception, the block performs the entry sequence atomically in one cycle. In that same cycle it raises a redirect with the fixed handler address. It also pulses a write strobe for the exception return address, which takes the value of the next-instruction address. An exception-return strobe restores the status word from the shadow copy and redirects to the stored return address. Decode, the general register file and handler software sit outside the block. The decision and the redirect are combinational in the cycle of the request. All register updates land on the following clock edge.

Top module: `exc_ctl_top`

## Requirements
- R1: After reset the block is in supervisor mode with interrupts globally disabled. Status, saved status and the enable mask all read zero, and the identifier (select 4) reads the `CPU_ID` parameter.
- R2: The status register is select 0. Bit 0 is the global interrupt enable and bit 1 is the user-mode flag (1 = user). All other bits read zero. The saved-status register is select 1 and has the same layout.
- R3: The pending register is select 3 and reads irq AND enable, where the enable mask is select 2, bit k per line k. It is read-only, so writes to it have no effect.
- R4: A hardware interrupt is taken only when the global enable is 1 and at least one request line with its enable bit set is high.
- R5: On entry, the old status is copied to saved status and both status bits are cleared. `nextPc` is stored as the return address, `epcWe` pulses for one cycle, and `redirectPc` equals `MEM_BASE + HANDLER_OFFSET` (0x20 by default) in the same cycle.
- R6: An exception return (`retReq`) copies saved status back into status and redirects, in the same cycle, to the stored return address.
- R7: At most one entry happens per cycle. The priority is interrupt, then unimplemented instruction, then trap, with `causeCode` 2, 3 and 1 respectively (0 when nothing is taken). An entry in the same cycle as `retReq` wins, and the return is dropped.
- R8: In user mode a control-register write is suppressed, a read returns zero, and `illegalAccess` is high in that cycle.
- R9: A control-register write in a cycle with an entry or a return has no effect.
- R10: The identifier register cannot be written. Unused selects 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | IRQ_COUNT | Level-sensitive interrupt requests |
| trapReq | input | 1 | Software trap strobe |
| badOpReq | input | 1 | Unimplemented instruction strobe |
| retReq | input | 1 | Exception return strobe |
| nextPc | input | XLEN | Address of the instruction after the current one |
| csrSel | input | 3 | Control register select |
| csrWe | input | 1 | Control register write |
| csrRe | input | 1 | Control register read |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data (zero when not reading) |
| illegalAccess | output | 1 | Access attempted in user mode |
| redirectValid | output | 1 | PC redirect request |
| redirectPc | output | XLEN | Redirect target |
| causeCode | output | 2 | Cause of the entry taken this cycle |
| epcWe | output | 1 | Return-address write strobe |
| retAddr | output | XLEN | Stored exception return address |
| userMode | output | 1 | Current user-mode flag |
| intEnable | output | 1 | Current global interrupt enable |

## Verification
The entry decision is tried with request lines that are raised but masked, with enabled lines while the global enable is off, and with enabled lines while it is on. These three cases separate a gate on the mask from a gate on the global bit. Simultaneous trap, unimplemented-instruction, interrupt and return strobes show whether the priority order holds and whether two entries could ever overlap. Accesses made in user mode, and writes in an entry cycle, show that suppressed writes leave the enable mask intact once supervisor mode returns. A long stretch of random stimulus, checked against a behavioural model every cycle, covers nested entries and returns.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_TRAP  = 2'd1,
    CAUSE_IRQ   = 2'd2,
    CAUSE_BADOP = 2'd3
  } causeE;

  localparam logic [2:0] SEL_STATUS  = 3'd0;
  localparam logic [2:0] SEL_SAVED   = 3'd1;
  localparam logic [2:0] SEL_ENABLE  = 3'd2;
  localparam logic [2:0] SEL_PENDING = 3'd3;
  localparam logic [2:0] SEL_ID      = 3'd4;

  // strobes from the sequencing control to the register datapath
  typedef struct packed {
    logic enter;
    logic leave;
    logic wrStatus;
    logic wrSaved;
    logic wrEnable;
  } ctlStrobeS;

endpackage

// File: rtl/exc_ctl_seq.sv
module exc_ctl_seq
  import exc_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      intPending,
  input  logic      pieBit,
  input  logic      userBit,
  input  logic      trapReq,
  input  logic      badOpReq,
  input  logic      retReq,
  input  logic      csrWe,
  input  logic      csrRe,
  input  logic [2:0] csrSel,
  output ctlStrobeS strobes,
  output causeE     cause,
  output logic      illegalAccess,
  output logic      readOk
);

  logic accessOk;
  logic quiet;
  logic wrGo;

  always_comb begin
    if (pieBit && intPending)  cause = CAUSE_IRQ;
    else if (badOpReq)         cause = CAUSE_BADOP;
    else if (trapReq)          cause = CAUSE_TRAP;
    else                       cause = CAUSE_NONE;
  end

  always_comb begin
    accessOk      = !userBit;
    illegalAccess = (csrWe || csrRe) && userBit;
    readOk        = csrRe && accessOk;

    strobes.enter = (cause != CAUSE_NONE);
    strobes.leave = retReq && (cause == CAUSE_NONE);

    quiet = !strobes.enter && !strobes.leave;
    wrGo  = csrWe && accessOk && quiet;

    strobes.wrStatus = wrGo && (csrSel == SEL_STATUS);
    strobes.wrSaved  = wrGo && (csrSel == SEL_SAVED);
    strobes.wrEnable = wrGo && (csrSel == SEL_ENABLE);
  end

  // R7
  single_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.enter, strobes.leave}));

  // R8
  user_write_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalAccess |-> !(strobes.wrStatus || strobes.wrSaved || strobes.wrEnable));

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cause == CAUSE_IRQ) |-> (pieBit && intPending));

endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs
  import exc_ctl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          IRQ_COUNT  = 32,
  parameter logic [31:0] HANDLER_PC = 32'h20,
  parameter logic [31:0] CPU_ID     = 32'h0000_1234
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeS            strobes,
  input  logic [XLEN-1:0]      csrWdata,
  input  logic [2:0]           csrSel,
  input  logic                 readOk,
  input  logic [XLEN-1:0]      nextPc,
  input  logic [IRQ_COUNT-1:0] irqLines,
  output logic                 pieBit,
  output logic                 userBit,
  output logic                 intPending,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 redirectValid,
  output logic [XLEN-1:0]      redirectPc,
  output logic                 epcWe,
  output logic [XLEN-1:0]      retAddr
);

  localparam int PAD = XLEN - 2;

  logic [1:0]           statusQ;
  logic [1:0]           savedQ;
  logic [IRQ_COUNT-1:0] enableQ;
  logic [IRQ_COUNT-1:0] pendVec;
  logic [XLEN-1:0]      epcQ;

  for (genvar k = 0; k < IRQ_COUNT; k++) begin : gPend
    assign pendVec[k] = irqLines[k] & enableQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      savedQ  <= '0;
      enableQ <= '0;
      epcQ    <= '0;
    end else if (strobes.enter) begin
      savedQ  <= statusQ;
      statusQ <= '0;
      epcQ    <= nextPc;
    end else if (strobes.leave) begin
      statusQ <= savedQ;
    end else begin
      if (strobes.wrStatus) statusQ <= csrWdata[1:0];
      if (strobes.wrSaved)  savedQ  <= csrWdata[1:0];
      if (strobes.wrEnable) enableQ <= csrWdata[IRQ_COUNT-1:0];
    end
  end

  always_comb begin
    csrRdata = '0;
    if (readOk) begin
      case (csrSel)
        SEL_STATUS:  csrRdata = {{PAD{1'b0}}, statusQ};
        SEL_SAVED:   csrRdata = {{PAD{1'b0}}, savedQ};
        SEL_ENABLE:  csrRdata = XLEN'(enableQ);
        SEL_PENDING: csrRdata = XLEN'(pendVec);
        SEL_ID:      csrRdata = XLEN'(CPU_ID);
        default:     csrRdata = '0;
      endcase
    end
  end

  assign pieBit        = statusQ[0];
  assign userBit       = statusQ[1];
  assign intPending    = |pendVec;
  assign redirectValid = strobes.enter || strobes.leave;
  assign redirectPc    = strobes.enter ? XLEN'(HANDLER_PC) : epcQ;
  assign epcWe         = strobes.enter;
  assign retAddr       = epcQ;

  // R5
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (statusQ == 2'b00));

  // R5
  entry_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (savedQ == $past(statusQ)));

  // R5
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (epcQ == $past(nextPc)));

  // R6
  return_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.leave |=> (statusQ == $past(savedQ)));

  // R9
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enter || strobes.leave) |=> $stable(enableQ));

endmodule

// File: rtl/exc_ctl_top.sv
module exc_ctl_top
  import exc_ctl_pkg::*;
#(
  parameter int          XLEN           = 32,
  parameter int          IRQ_COUNT      = 32,
  parameter logic [31:0] MEM_BASE       = 32'h0,
  parameter logic [31:0] HANDLER_OFFSET = 32'h20,
  parameter logic [31:0] CPU_ID         = 32'h0000_1234
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_COUNT-1:0] irqLines,
  input  logic                 trapReq,
  input  logic                 badOpReq,
  input  logic                 retReq,
  input  logic [XLEN-1:0]      nextPc,
  input  logic [2:0]           csrSel,
  input  logic                 csrWe,
  input  logic                 csrRe,
  input  logic [XLEN-1:0]      csrWdata,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 illegalAccess,
  output logic                 redirectValid,
  output logic [XLEN-1:0]      redirectPc,
  output logic [1:0]           causeCode,
  output logic                 epcWe,
  output logic [XLEN-1:0]      retAddr,
  output logic                 userMode,
  output logic                 intEnable
);

  localparam logic [31:0] HANDLER_PC = MEM_BASE + HANDLER_OFFSET;

  ctlStrobeS strobes;
  causeE     cause;
  logic      pieBit;
  logic      userBit;
  logic      intPending;
  logic      readOk;

  exc_ctl_seq u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .intPending   (intPending),
    .pieBit       (pieBit),
    .userBit      (userBit),
    .trapReq      (trapReq),
    .badOpReq     (badOpReq),
    .retReq       (retReq),
    .csrWe        (csrWe),
    .csrRe        (csrRe),
    .csrSel       (csrSel),
    .strobes      (strobes),
    .cause        (cause),
    .illegalAccess(illegalAccess),
    .readOk       (readOk)
  );

  exc_ctl_regs #(
    .XLEN      (XLEN),
    .IRQ_COUNT (IRQ_COUNT),
    .HANDLER_PC(HANDLER_PC),
    .CPU_ID    (CPU_ID)
  ) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .csrWdata     (csrWdata),
    .csrSel       (csrSel),
    .readOk       (readOk),
    .nextPc       (nextPc),
    .irqLines     (irqLines),
    .pieBit       (pieBit),
    .userBit      (userBit),
    .intPending   (intPending),
    .csrRdata     (csrRdata),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc),
    .epcWe        (epcWe),
    .retAddr      (retAddr)
  );

  assign causeCode = cause;
  assign userMode  = userBit;
  assign intEnable = pieBit;

  // R1
  reset_mode_chk: assert property (@(posedge clk)
    !rstN |=> (!userMode && !intEnable));

endmodule

// File: tb/exc_ctl_top_bench.sv
`timescale 1ns/1ps
module exc_ctl_top_bench;

  localparam logic [31:0] HANDLER = 32'h20;
  localparam logic [31:0] ID      = 32'h0000_1234;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        trapReq = 1'b0, badOpReq = 1'b0, retReq = 1'b0;
  logic [31:0] nextPc = '0;
  logic [2:0]  csrSel = '0;
  logic        csrWe = 1'b0, csrRe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, redirectPc, retAddr;
  logic        illegalAccess, redirectValid, epcWe, userMode, intEnable;
  logic [1:0]  causeCode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int unsigned mStatus = 0, mSaved = 0, mEnable = 0, mEpc = 0;

  always #2.5 clk = ~clk;

  exc_ctl_top #(.CPU_ID(ID)) u_exc_ctl_top (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .trapReq(trapReq),
    .badOpReq(badOpReq), .retReq(retReq), .nextPc(nextPc), .csrSel(csrSel),
    .csrWe(csrWe), .csrRe(csrRe), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .illegalAccess(illegalAccess), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .causeCode(causeCode), .epcWe(epcWe),
    .retAddr(retAddr), .userMode(userMode), .intEnable(intEnable)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    irqLines = '0; trapReq = 0; badOpReq = 0; retReq = 0;
    csrWe = 0; csrRe = 0; csrSel = 0; csrWdata = 0;
  endtask

  // one cycle: compare outputs against the model, then advance the model
  task automatic cyc(input string tag);
    int unsigned pend, rd, cause, pc;
    bit user, enter, leave, okAcc;
    #1;
    pend  = irqLines & mEnable;
    user  = (mStatus & 2) != 0;
    if ((mStatus & 1) && pend != 0) cause = 2;
    else if (badOpReq)              cause = 3;
    else if (trapReq)               cause = 1;
    else                            cause = 0;
    enter = cause != 0;
    leave = retReq && !enter;
    okAcc = !user;
    rd = 0;
    if (csrRe && okAcc) begin
      case (csrSel)
        0: rd = mStatus;
        1: rd = mSaved;
        2: rd = mEnable;
        3: rd = pend;
        4: rd = ID;
        default: rd = 0;
      endcase
    end
    pc = enter ? HANDLER : mEpc;
    chk(tag, "csrRdata", csrRdata, rd);
    chk(tag, "illegalAccess", {31'b0, illegalAccess}, {31'b0, (csrWe || csrRe) && user});
    chk(tag, "redirectValid", {31'b0, redirectValid}, {31'b0, enter || leave});
    if (enter || leave) chk(tag, "redirectPc", redirectPc, pc);
    chk(tag, "causeCode", {30'b0, causeCode}, cause);
    chk(tag, "epcWe", {31'b0, epcWe}, {31'b0, enter});
    chk(tag, "retAddr", retAddr, mEpc);
    chk(tag, "userMode", {31'b0, userMode}, {31'b0, user});
    chk(tag, "intEnable", {31'b0, intEnable}, mStatus & 1);
    @(posedge clk);
    if (enter) begin
      mSaved = mStatus; mStatus = 0; mEpc = nextPc;
    end else if (leave) begin
      mStatus = mSaved;
    end else if (csrWe && okAcc) begin
      if (csrSel == 0) mStatus = csrWdata & 3;
      if (csrSel == 1) mSaved  = csrWdata & 3;
      if (csrSel == 2) mEnable = csrWdata;
    end
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input int sel, input logic [31:0] d);
    idle(); csrWe = 1; csrSel = sel[2:0]; csrWdata = d; cyc(tag);
  endtask

  task automatic rdc(input string tag, input int sel);
    idle(); csrRe = 1; csrSel = sel[2:0]; cyc(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdc("R1", 0); rdc("R1", 1); rdc("R1", 2); rdc("R1", 4);
    // R2 status layout: only two low bits stick
    wr("R2", 0, 32'hFFFF_FFFD); rdc("R2", 0);
    wr("R2", 0, 32'h0);
    // R3 pending = irq & enable, read-only
    wr("R3", 2, 32'h0000_00F0);
    idle(); irqLines = 32'h11; csrRe = 1; csrSel = 3; cyc("R3");
    idle(); irqLines = 32'h11; csrWe = 1; csrSel = 3; csrWdata = '1; cyc("R3");
    idle(); irqLines = 32'h11; csrRe = 1; csrSel = 3; cyc("R3");
    rdc("R10", 2);
    // R4 enabled line with PIE off: no entry
    idle(); irqLines = 32'h20; cyc("R4");
    wr("R4", 0, 32'h1);
    idle(); irqLines = 32'h0F; cyc("R4");
    // R5 entry on enabled interrupt
    idle(); irqLines = 32'h20; nextPc = 32'h1000; cyc("R5");
    rdc("R5", 0); rdc("R5", 1);
    // R6 return
    idle(); retReq = 1; cyc("R6");
    rdc("R6", 0);
    // R7 priority: interrupt over trap, then unimplemented over trap
    idle(); irqLines = 32'h40; trapReq = 1; nextPc = 32'h2004; cyc("R7");
    idle(); badOpReq = 1; trapReq = 1; nextPc = 32'h3008; cyc("R7");
    idle(); trapReq = 1; retReq = 1; nextPc = 32'h400C; cyc("R7");
    idle(); retReq = 1; cyc("R7");
    // R8 user mode access
    wr("R8", 0, 32'h2);
    wr("R8", 2, 32'h0); rdc("R8", 2); rdc("R8", 0);
    idle(); trapReq = 1; nextPc = 32'h5010; cyc("R8");
    rdc("R8", 2); rdc("R8", 1);
    // R9 write in entry cycle dropped
    idle(); trapReq = 1; csrWe = 1; csrSel = 2; csrWdata = 32'h5; cyc("R9");
    rdc("R9", 2);
    idle(); retReq = 1; csrWe = 1; csrSel = 0; csrWdata = 32'h3; cyc("R9");
    rdc("R9", 0);
    // R10 id read-only, unused selects zero
    wr("R10", 4, 32'hDEAD_BEEF); rdc("R10", 4); rdc("R10", 5); rdc("R10", 7);
    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      idle();
      irqLines = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      trapReq  = ($urandom % 8) == 0;
      badOpReq = ($urandom % 12) == 0;
      retReq   = ($urandom % 6) == 0;
      csrWe    = ($urandom % 4) == 0;
      csrRe    = ($urandom % 2) == 0;
      csrSel   = 3'($urandom % 8);
      csrWdata = $urandom;
      nextPc   = $urandom & 32'hFFFF_FFFC;
      cyc("R7");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule